// File: doc/BRIEF.md
# Shifter-Fed Data-Processing Unit with Condition Flags

A purely combinational data-processing stage for a 32-bit integer pipeline. The first operand goes straight into the arithmetic/logic stage. The second operand first passes through a barrel shifter, which can shift it left logically, right logically, right arithmetically or rotate it right, by 0 to 31 places. The stage covers these operations:

- moves: a plain move and an inverting move
- arithmetic: add, subtract and reverse subtract
- bitwise logic: AND, OR, XOR and bit-clear
- flag-only forms: compare, test and test-equivalence, which update the flags and write no result
- a signed saturating add

For each operation the unit returns the result and a write-enable for the destination register. It also returns the next N, Z, C and V condition flags and the next state of a sticky saturation flag. The current flags come in as inputs and go back out unchanged whenever an operation does not update them. The surrounding pipeline stores the flags and the register file.

Top module: `shift_alu`

## Requirements
- R1: `op_i` selects the operation: 0 move (S), 1 inverted move (~S), 2 add (A+S), 3 subtract (A-S), 4 reverse subtract (S-A), 5 AND, 6 OR, 7 XOR, 8 bit-clear (A & ~S). Here A is `opa_i` and S is the shifted `opb_i`. Each of these drives `wr_en_o` high and puts the value on `result_o`.
- R2: `sh_type_i` selects the shift: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. `sh_amt_i` gives the count. A count of 0 passes `opb_i` through unchanged.
- R3: For move, logic, test and test-equivalence operations, the next C is the last bit pushed out by the shifter. For a left shift by n this is bit 32-n of `opb_i`. For the right shifts and the rotate it is bit n-1. When the count is 0, C keeps its incoming value.
- R4: For those same operations, N is result bit 31 and Z is 1 exactly when the result is zero. V keeps its incoming value.
- R5: For add, subtract, reverse subtract and compare, C is the adder carry-out and V is signed overflow. A subtraction sets C when it produces no borrow. Adding 0x7fffffff and 1 wraps to 0x80000000 and sets V.
- R6: `flags_o` is a 4-bit vector with N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. Unless `set_flags_i` is 1, it equals `flags_i`. The flag-only forms in R7 are the exception.
- R7: Code 9 compares (A-S), code 10 tests (A&S) and code 11 tests equivalence (A^S). These forms always update the flags, even with `set_flags_i` low, and hold `wr_en_o` low.
- R8: Code 12 adds `opa_i` and the unshifted `opb_i` as signed numbers. On positive overflow the result clamps to 0x7fffffff, and on negative overflow to 0x80000000. An overflow also sets `q_o`. This operation never changes N, Z, C or V.
- R9: `q_o` is sticky. It follows `q_i` unless `q_clr_i` is 1, in which case it clears. A saturation in the same step still sets it.
- R10: Codes 13 to 15 write nothing and leave N, Z, C and V unchanged, whatever `set_flags_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand, unshifted |
| opb_i | input | 32 | Second operand, fed through the shifter |
| sh_type_i | input | 2 | Shift kind |
| sh_amt_i | input | 5 | Shift count |
| set_flags_i | input | 1 | Permit flag update |
| flags_i | input | 4 | Current N,Z,C,V |
| q_i | input | 1 | Current sticky saturation flag |
| q_clr_i | input | 1 | Clear the sticky saturation flag |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Next N,Z,C,V |
| q_o | output | 1 | Next sticky saturation flag |

## Verification
The hardest case to reach from the ports is the one where the shifter carry and the incoming flags collide. A zero shift count must carry the old C through while N and Z still change. A flag-only form issued with `set_flags_i` low must still rewrite the flags. The stimulus sets the incoming C and V to values the operation would never produce itself, so a kept flag can be told apart from a computed one. Saturation is driven at both clamps, and also in the same step as a clear request.

// File: rtl/shift_alu_pkg.sv
package shift_alu_pkg;

    typedef enum logic [3:0] {
        OP_MOV  = 4'd0,
        OP_MVN  = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_RSB  = 4'd4,
        OP_AND  = 4'd5,
        OP_ORR  = 4'd6,
        OP_EOR  = 4'd7,
        OP_BIC  = 4'd8,
        OP_CMP  = 4'd9,
        OP_TST  = 4'd10,
        OP_TEQ  = 4'd11,
        OP_QADD = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // flag-only forms: result discarded
    function automatic logic op_is_test(alu_op_e op);
        return (op == OP_CMP) || (op == OP_TST) || (op == OP_TEQ);
    endfunction

    // operations whose C comes from the shifter
    function automatic logic op_is_logical(alu_op_e op);
        return (op == OP_MOV) || (op == OP_MVN) || (op == OP_AND) ||
               (op == OP_ORR) || (op == OP_EOR) || (op == OP_BIC) ||
               (op == OP_TST) || (op == OP_TEQ);
    endfunction

    // operations whose C and V come from the adder
    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_RSB) ||
               (op == OP_CMP);
    endfunction

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
    import shift_alu_pkg::*;
#(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  shift_e         kind,
    input  logic [SHW-1:0] amt,
    input  logic           c_in,
    output logic [W-1:0]   dout,
    output logic           c_out
);
    always_comb begin
        int n;
        n     = int'(amt);
        dout  = din;
        c_out = c_in;
        if (n != 0) begin
            unique case (kind)
                SH_LSL: begin
                    dout  = din << n;
                    c_out = din[W - n];
                end
                SH_LSR: begin
                    dout  = din >> n;
                    c_out = din[n - 1];
                end
                SH_ASR: begin
                    dout  = $signed(din) >>> n;
                    c_out = din[n - 1];
                end
                SH_ROR: begin
                    dout  = (din >> n) | (din << (W - n));
                    c_out = din[n - 1];
                end
            endcase
        end
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
        ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import shift_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] s,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_MOV:          y = s;
            OP_MVN:          y = ~s;
            OP_AND, OP_TST:  y = a & s;
            OP_ORR:          y = a | s;
            OP_EOR, OP_TEQ:  y = a ^ s;
            OP_BIC:          y = a & ~s;
            default:         y = '0;
        endcase
    end
endmodule

// File: rtl/shift_alu.sv
module shift_alu
    import shift_alu_pkg::*;
#(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [3:0]     op_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    input  logic [1:0]     sh_type_i,
    input  logic [SHW-1:0] sh_amt_i,
    input  logic           set_flags_i,
    input  logic [3:0]     flags_i,
    input  logic           q_i,
    input  logic           q_clr_i,
    output logic [W-1:0]   result_o,
    output logic           wr_en_o,
    output logic [3:0]     flags_o,
    output logic           q_o
);
    localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

    alu_op_e        op;
    nzcv_t          cur, nxt;
    logic [W-1:0]   shv, logic_y, add_x, add_y, add_s;
    logic           sh_c, add_cin, add_co, add_ov, sat_hit, upd;

    assign op  = alu_op_e'(op_i);
    assign cur = nzcv_t'(flags_i);

    alu_shifter #(.W(W)) u_shift (
        .din   (opb_i),
        .kind  (shift_e'(sh_type_i)),
        .amt   (sh_amt_i),
        .c_in  (cur.c),
        .dout  (shv),
        .c_out (sh_c)
    );

    alu_logic #(.W(W)) u_logic (
        .op (op),
        .a  (opa_i),
        .s  (shv),
        .y  (logic_y)
    );

    // one adder shared by every arithmetic form and the saturating add
    always_comb begin
        unique case (op)
            OP_SUB, OP_CMP: begin add_x = opa_i; add_y = ~shv;   add_cin = 1'b1; end
            OP_RSB:         begin add_x = shv;   add_y = ~opa_i; add_cin = 1'b1; end
            OP_QADD:        begin add_x = opa_i; add_y = opb_i;  add_cin = 1'b0; end
            default:        begin add_x = opa_i; add_y = shv;    add_cin = 1'b0; end
        endcase
    end

    alu_adder #(.W(W)) u_add (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_s),
        .cout (add_co),
        .ovf  (add_ov)
    );

    always_comb begin
        sat_hit = (op == OP_QADD) && add_ov;

        if (op_is_arith(op))
            result_o = add_s;
        else if (op == OP_QADD)
            result_o = sat_hit ? (opa_i[W-1] ? SAT_MIN : SAT_MAX) : add_s;
        else
            result_o = logic_y;

        wr_en_o = (op_is_logical(op) && !op_is_test(op)) ||
                  (op_is_arith(op) && op != OP_CMP) || (op == OP_QADD);

        nxt.n = result_o[W-1];
        nxt.z = (result_o == '0);
        nxt.c = op_is_arith(op) ? add_co : sh_c;
        nxt.v = op_is_arith(op) ? add_ov : cur.v;

        upd     = op_is_test(op) ||
                  (set_flags_i && (op_is_arith(op) || op_is_logical(op)));
        flags_o = upd ? nxt : cur;
        q_o     = (q_i && !q_clr_i) || sat_hit;
    end
endmodule

// File: rtl/shift_alu_chk.sv
module shift_alu_chk #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input logic [3:0]     op_i,
    input logic [W-1:0]   opa_i,
    input logic [W-1:0]   opb_i,
    input logic [1:0]     sh_type_i,
    input logic [SHW-1:0] sh_amt_i,
    input logic           set_flags_i,
    input logic [3:0]     flags_i,
    input logic           q_i,
    input logic           q_clr_i,
    input logic [W-1:0]   result_o,
    input logic           wr_en_o,
    input logic [3:0]     flags_o,
    input logic           q_o
);
    logic is_tst, is_log, is_ari;

    always_comb begin
        is_tst = (op_i >= 4'd9) && (op_i <= 4'd11);
        is_log = (op_i <= 4'd1) || ((op_i >= 4'd5) && (op_i <= 4'd11) && op_i != 4'd9);
        is_ari = ((op_i >= 4'd2) && (op_i <= 4'd4)) || op_i == 4'd9;

        AST_TEST_NO_WRITE: assert (!is_tst || !wr_en_o);  // R7
        AST_FLAGS_HELD: assert (set_flags_i || is_tst || flags_o == flags_i);  // R6
        AST_Q_STICKY: assert (!(q_i && !q_clr_i) || q_o);  // R9
        AST_Z_FROM_RESULT: assert (!((is_log || is_ari) && (set_flags_i || is_tst))
                                   || flags_o[2] == (result_o == '0));  // R4
        AST_V_KEPT_LOGIC: assert (!is_log || flags_o[0] == flags_i[0]);  // R4
        AST_C_KEPT_ZERO_AMT: assert (!(is_log && sh_amt_i == '0)
                                     || flags_o[1] == flags_i[1]);  // R3
        AST_QADD_NZCV: assert (op_i != 4'd12 || flags_o == flags_i);  // R8
        AST_ROR_BITS: assert (!(op_i == 4'd0 && sh_type_i == 2'd3)
                              || $countones(result_o) == $countones(opb_i)
                              || opa_i == '1);  // R2
        AST_UNDEF_IDLE: assert (op_i < 4'd13 || (!wr_en_o && flags_o == flags_i));  // R10
    end
endmodule

bind shift_alu shift_alu_chk #(.W(W)) u_chk (.*);

// File: tb/shift_alu_bench.sv
module shift_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    always #10 clk = ~clk;

    logic [3:0]  op;
    logic [31:0] a, b, res;
    logic [1:0]  st;
    logic [4:0]  sa;
    logic        sf, q, qc, we, qo;
    logic [3:0]  fl, flo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    shift_alu u_shift_alu (
        .op_i(op), .opa_i(a), .opb_i(b), .sh_type_i(st), .sh_amt_i(sa),
        .set_flags_i(sf), .flags_i(fl), .q_i(q), .q_clr_i(qc),
        .result_o(res), .wr_en_o(we), .flags_o(flo), .q_o(qo)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] o, logic [31:0] x, logic [31:0] y,
                         logic [1:0] t, logic [4:0] n, logic s,
                         logic [3:0] f, logic qi, logic c);
        @(negedge clk);
        op = o; a = x; b = y; st = t; sa = n; sf = s; fl = f; q = qi; qc = c;
        #2;
    endtask

    task automatic t_idle();
        drive(4'd0, 0, 0, 2'd0, 5'd0, 1'b0, 4'b0000, 1'b0, 1'b0);
        chk("R1 idle result", res, 32'h0);
        chk("R1 idle wr_en", {31'b0, we}, 1);
        chk("R6 idle flags", {28'b0, flo}, 0);
        chk("R9 idle q", {31'b0, qo}, 0);
    endtask

    task automatic t_shifts();
        drive(4'd0, 0, 32'h80000001, 2'd0, 5'd1, 1'b1, 4'b0000, 1'b0, 1'b0);
        chk("R2 lsl1", res, 32'h2);
        chk("R3 lsl1 flags", {28'b0, flo}, 4'b0010);
        drive(4'd0, 0, 32'h000000F8, 2'd1, 5'd4, 1'b1, 4'b0000, 1'b0, 1'b0);
        chk("R2 lsr4", res, 32'hF);
        chk("R3 lsr4 flags", {28'b0, flo}, 4'b0010);
        drive(4'd0, 0, 32'h80000010, 2'd2, 5'd4, 1'b1, 4'b0011, 1'b0, 1'b0);
        chk("R2 asr4", res, 32'hF8000001);
        chk("R4 asr4 flags", {28'b0, flo}, 4'b1001);
        drive(4'd0, 0, 32'h123456F8, 2'd3, 5'd8, 1'b1, 4'b0000, 1'b0, 1'b0);
        chk("R2 ror8", res, 32'hF8123456);
        chk("R3 ror8 flags", {28'b0, flo}, 4'b1010);
        drive(4'd0, 0, 32'h0, 2'd0, 5'd0, 1'b1, 4'b0011, 1'b0, 1'b0);
        chk("R3 zero amt keeps C, R4 Z", {28'b0, flo}, 4'b0111);
        drive(4'd1, 0, 32'h0, 2'd0, 5'd0, 1'b1, 4'b0000, 1'b0, 1'b0);
        chk("R1 mvn", res, 32'hFFFFFFFF);
        chk("R4 mvn N", {28'b0, flo}, 4'b1000);
    endtask

    task automatic t_arith();
        drive(4'd2, 32'h7FFFFFFF, 32'h1, 2'd0, 5'd0, 1'b1, 4'b0000, 1'b0, 1'b0);
        chk("R5 add wrap", res, 32'h80000000);
        chk("R5 add wrap flags", {28'b0, flo}, 4'b1001);
        drive(4'd2, 32'hFFFFFFFF, 32'h1, 2'd0, 5'd0, 1'b1, 4'b0001, 1'b0, 1'b0);
        chk("R5 add carry flags", {28'b0, flo}, 4'b0110);
        drive(4'd3, 32'h1, 32'h1, 2'd0, 5'd0, 1'b1, 4'b0000, 1'b0, 1'b0);
        chk("R5 sub no borrow flags", {28'b0, flo}, 4'b0110);
        drive(4'd3, 32'h0, 32'h1, 2'd0, 5'd0, 1'b1, 4'b0010, 1'b0, 1'b0);
        chk("R5 sub borrow", res, 32'hFFFFFFFF);
        chk("R5 sub borrow flags", {28'b0, flo}, 4'b1000);
        drive(4'd4, 32'h5, 32'h0, 2'd0, 5'd0, 1'b0, 4'b1010, 1'b0, 1'b0);
        chk("R1 rsb negate", res, 32'hFFFFFFFB);
        chk("R6 rsb flags held", {28'b0, flo}, 4'b1010);
        drive(4'd2, 32'h3, 32'h3, 2'd0, 5'd1, 1'b0, 4'b0000, 1'b0, 1'b0);
        chk("R1 add shifted x3", res, 32'h9);
    endtask

    task automatic t_logic();
        drive(4'd5, 32'hF0F0F0F0, 32'hFF00FF00, 2'd0, 5'd0, 1'b0, 0, 1'b0, 1'b0);
        chk("R1 and", res, 32'hF000F000);
        drive(4'd6, 32'hF0F0F0F0, 32'hFF00FF00, 2'd0, 5'd0, 1'b0, 0, 1'b0, 1'b0);
        chk("R1 orr", res, 32'hFFF0FFF0);
        drive(4'd7, 32'hF0F0F0F0, 32'hFF00FF00, 2'd0, 5'd0, 1'b0, 0, 1'b0, 1'b0);
        chk("R1 eor", res, 32'h0FF00FF0);
        drive(4'd8, 32'hF0F0F0F0, 32'hFF00FF00, 2'd0, 5'd0, 1'b0, 0, 1'b0, 1'b0);
        chk("R1 bic", res, 32'h00F000F0);
        chk("R1 bic wr_en", {31'b0, we}, 1);
    endtask

    task automatic t_tests();
        drive(4'd9, 32'h55, 32'h55, 2'd0, 5'd0, 1'b0, 4'b0000, 1'b0, 1'b0);
        chk("R7 cmp wr_en", {31'b0, we}, 0);
        chk("R7 cmp flags", {28'b0, flo}, 4'b0110);
        drive(4'd10, 32'hF0, 32'h0F, 2'd0, 5'd0, 1'b0, 4'b0001, 1'b0, 1'b0);
        chk("R7 tst flags", {28'b0, flo}, 4'b0101);
        chk("R7 tst wr_en", {31'b0, we}, 0);
        drive(4'd11, 32'h80000000, 32'h80000000, 2'd0, 5'd0, 1'b0, 4'b1000, 1'b0, 1'b0);
        chk("R7 teq flags", {28'b0, flo}, 4'b0100);
    endtask

    task automatic t_sat();
        drive(4'd12, 32'h7FFFFFFF, 32'h1, 2'd0, 5'd0, 1'b1, 4'b0000, 1'b0, 1'b0);
        chk("R8 sat max", res, 32'h7FFFFFFF);
        chk("R8 sat q", {31'b0, qo}, 1);
        chk("R8 nzcv kept", {28'b0, flo}, 4'b0000);
        drive(4'd12, 32'h80000000, 32'hFFFFFFFF, 2'd0, 5'd0, 1'b1, 4'b0101, 1'b0, 1'b0);
        chk("R8 sat min", res, 32'h80000000);
        chk("R8 sat min nzcv", {28'b0, flo}, 4'b0101);
        drive(4'd12, 32'h5, 32'hFFFFFFFD, 2'd0, 5'd4, 1'b1, 4'b0000, 1'b0, 1'b0);
        chk("R8 no sat unshifted", res, 32'h2);
        chk("R9 q stays clear", {31'b0, qo}, 0);
        drive(4'd12, 32'h5, 32'h1, 2'd0, 5'd0, 1'b0, 4'b0000, 1'b1, 1'b0);
        chk("R9 q sticky", {31'b0, qo}, 1);
        drive(4'd0, 0, 0, 2'd0, 5'd0, 1'b0, 4'b0000, 1'b1, 1'b1);
        chk("R9 q cleared", {31'b0, qo}, 0);
        drive(4'd12, 32'h7FFFFFFF, 32'h7FFFFFFF, 2'd0, 5'd0, 1'b0, 4'b0000, 1'b1, 1'b1);
        chk("R9 set beats clear", {31'b0, qo}, 1);
    endtask

    task automatic t_undef();
        drive(4'd13, 32'h0, 32'h0, 2'd0, 5'd0, 1'b1, 4'b1001, 1'b0, 1'b0);
        chk("R10 undef wr_en", {31'b0, we}, 0);
        chk("R10 undef flags", {28'b0, flo}, 4'b1001);
        drive(4'd15, 32'h1, 32'h1, 2'd0, 5'd0, 1'b1, 4'b0110, 1'b0, 1'b0);
        chk("R10 undef15 flags", {28'b0, flo}, 4'b0110);
    endtask

    initial begin
        op = 0; a = 0; b = 0; st = 0; sa = 0; sf = 0; fl = 0; q = 0; qc = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_shifts();
        t_arith();
        t_logic();
        t_tests();
        t_sat();
        t_undef();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule